// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from normal execution into an exception handler. When a pending exception is presented in the idle state, it captures the current status word, program counter, supervisor stack pointer and vector base. It then builds the supervisor-mode status word with tracing off. For an interrupt, it also raises the priority mask to the interrupt level.

Next it obtains an 8-bit vector number. An interrupt gets its number from an acknowledge read in CPU space. Any other exception gets it from an internal code. The block then pushes the program counter and the original status word onto the supervisor stack. It reads the handler address from the vector table and loads it into the program counter. A one-cycle completion pulse marks the end.

Every memory access goes through one request/acknowledge master port. Each access holds its request until the responder answers with an acknowledge or an error.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `bus_req` are low.
- R2: The status word written to the stack is the value of `sr_in` captured when the exception was accepted, before any bit was changed.
- R3: On completion, `sr_out` has bit 13 (supervisor) set and bits 15 and 14 (trace) cleared. All other bits equal the captured status, except as stated in R4.
- R4: For an interrupt, `sr_out[10:8]` equals `req_level`. For any other exception, those bits keep their captured value.
- R5: For an interrupt, the first bus access is a read with `bus_fc`=7, `bus_size`=0 (byte) and address {29 ones, `req_level`}. The vector number is `bus_rdata[7:0]` at the acknowledge.
- R6: For a non-interrupt exception, no CPU-space access takes place, and the vector number is `req_code`.
- R7: If the interrupt acknowledge ends with `bus_err`, the vector number becomes 24.
- R8: Two stack writes follow, both with `bus_fc`=5. The first is the program counter as a long word (`bus_size`=2) at `ssp_in`-4. The second is the status word as a 16-bit word (`bus_size`=1, data in `bus_wdata[15:0]`) at `ssp_in`-6. On completion `ssp_out` equals `ssp_in`-6.
- R9: The handler fetch is a long read with `bus_fc`=5, at address `vbr_in` + 4 × vector number, modulo 2^32.
- R10: `pc_out` takes the fetched handler address. `done` is high for exactly one cycle, at which point the block returns to idle.
- R11: Once `bus_req` is high, it and the address, space, size, direction and write data of the access stay unchanged until `bus_ack` or `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception pending; accepted when idle |
| req_irq | input | 1 | 1 = interrupt, 0 = trap or internal error |
| req_code | input | 8 | Internal vector number for non-interrupts |
| req_level | input | 3 | Interrupt priority level |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Program counter to save |
| ssp_in | input | 32 | Supervisor stack pointer |
| vbr_in | input | 32 | Vector table base |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sr_out | output | 16 | Working status word |
| pc_out | output | 32 | Handler address after completion |
| ssp_out | output | 32 | Stack pointer after the pushes |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write |
| bus_fc | output | 3 | Address space: 5 supervisor data, 7 CPU space |
| bus_size | output | 2 | 0 byte, 1 word, 2 long |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ack |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access ended with error |

## Verification
The hardest case to reach is an interrupt acknowledge that ends in an error. The vector number then comes from neither the bus nor the request, and the fetch address has to reflect the spurious number. The stimulus makes the bench responder answer CPU-space reads with an error in a share of the random interrupts, and also in a directed case. A second hard case is address wrap-around in the stack and vector table arithmetic. Directed runs place the stack pointer near zero and the vector base near the top of memory, using vector 255. Random response delays also keep accesses waiting, so that the hold requirement is exercised.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int ADDR_W = 32;
    localparam int SR_W   = 16;
    localparam int VEC_W  = 8;
    localparam int LVL_W  = 3;

    localparam int SR_T1_BIT   = 15;
    localparam int SR_T0_BIT   = 14;
    localparam int SR_S_BIT    = 13;
    localparam int SR_MASK_LSB = 8;

    localparam logic [2:0] FC_SUP_DATA = 3'd5;
    localparam logic [2:0] FC_CPU      = 3'd7;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAVE_SR = 3'd1,
        ST_GET_VEC = 3'd2,
        ST_PUSH_PC = 3'd3,
        ST_PUSH_SR = 3'd4,
        ST_FETCH   = 3'd5,
        ST_LOAD_PC = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [SR_W-1:0]     sr_saved;
        logic [SR_W-1:0]     sr_work;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   ssp;
        logic [ADDR_W-1:0]   vbr;
        logic [VEC_W-1:0]    vec;
        logic [VEC_W-1:0]    code;
        logic [LVL_W-1:0]    level;
        logic                irq;
    } seq_regs_t;
endpackage

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_entry_pkg::*;
(
    input  logic [SR_W-1:0]  sr_in,
    input  logic             set_mask,
    input  logic [LVL_W-1:0] level,
    output logic [SR_W-1:0]  sr_out
);
    always_comb begin
        sr_out            = sr_in;
        sr_out[SR_S_BIT]  = 1'b1;
        sr_out[SR_T1_BIT] = 1'b0;
        sr_out[SR_T0_BIT] = 1'b0;
        if (set_mask) begin
            sr_out[SR_MASK_LSB +: LVL_W] = level;
        end
    end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
    import exc_entry_pkg::*;
(
    input  logic [ADDR_W-1:0] vbr,
    input  logic [VEC_W-1:0]  vec,
    input  logic [LVL_W-1:0]  level,
    output logic [ADDR_W-1:0] table_addr,
    output logic [ADDR_W-1:0] iack_addr
);
    localparam int PAD_W = ADDR_W - VEC_W - 2;

    always_comb begin
        table_addr = vbr + {{PAD_W{1'b0}}, vec, 2'b00};
        iack_addr  = {{(ADDR_W-LVL_W){1'b1}}, level};
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter logic [VEC_W-1:0] SPURIOUS_VEC = 8'd24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_irq,
    input  logic [VEC_W-1:0]  req_code,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic [ADDR_W-1:0] vbr_in,
    output logic              busy,
    output logic              done,
    output logic [SR_W-1:0]   sr_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              bus_req,
    output logic              bus_we,
    output logic [2:0]        bus_fc,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);
    localparam logic [ADDR_W-1:0] PC_BYTES = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] SR_BYTES = ADDR_W'(2);

    seq_regs_t         r_q, r_d;
    logic [SR_W-1:0]   sr_entry;
    logic [ADDR_W-1:0] table_addr;
    logic [ADDR_W-1:0] iack_addr;
    logic              bus_end;

    exc_sr_update u_sr_update (
        .sr_in    (r_q.sr_work),
        .set_mask (r_q.irq),
        .level    (r_q.level),
        .sr_out   (sr_entry)
    );

    exc_vec_addr u_vec_addr (
        .vbr        (r_q.vbr),
        .vec        (r_q.vec),
        .level      (r_q.level),
        .table_addr (table_addr),
        .iack_addr  (iack_addr)
    );

    assign bus_end = bus_ack | bus_err;

    always_comb begin
        r_d       = r_q;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_fc    = FC_SUP_DATA;
        bus_size  = SZ_LONG;
        bus_addr  = '0;
        bus_wdata = '0;
        done      = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.sr_saved = sr_in;
                    r_d.sr_work  = sr_in;
                    r_d.pc       = pc_in;
                    r_d.ssp      = ssp_in;
                    r_d.vbr      = vbr_in;
                    r_d.code     = req_code;
                    r_d.level    = req_level;
                    r_d.irq      = req_irq;
                    r_d.st       = ST_SAVE_SR;
                end
            end
            ST_SAVE_SR: begin
                r_d.sr_work = sr_entry;
                r_d.st      = ST_GET_VEC;
            end
            ST_GET_VEC: begin
                if (r_q.irq) begin
                    bus_req  = 1'b1;
                    bus_fc   = FC_CPU;
                    bus_size = SZ_BYTE;
                    bus_addr = iack_addr;
                    if (bus_ack) begin
                        r_d.vec = bus_rdata[VEC_W-1:0];
                        r_d.st  = ST_PUSH_PC;
                    end else if (bus_err) begin
                        r_d.vec = SPURIOUS_VEC;
                        r_d.st  = ST_PUSH_PC;
                    end
                end else begin
                    r_d.vec = r_q.code;
                    r_d.st  = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = r_q.ssp - PC_BYTES;
                bus_wdata = r_q.pc;
                if (bus_end) begin
                    r_d.ssp = r_q.ssp - PC_BYTES;
                    r_d.st  = ST_PUSH_SR;
                end
            end
            ST_PUSH_SR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_size  = SZ_WORD;
                bus_addr  = r_q.ssp - SR_BYTES;
                bus_wdata = {{(ADDR_W-SR_W){1'b0}}, r_q.sr_saved};
                if (bus_end) begin
                    r_d.ssp = r_q.ssp - SR_BYTES;
                    r_d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = table_addr;
                if (bus_end) begin
                    r_d.pc = bus_rdata;
                    r_d.st = ST_LOAD_PC;
                end
            end
            ST_LOAD_PC: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign sr_out  = r_q.sr_work;
    assign pc_out  = r_q.pc;
    assign ssp_out = r_q.ssp;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [15:0] sr_out,
    input logic        bus_req,
    input logic        bus_we,
    input logic [2:0]  bus_fc,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        bus_err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_sup_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sr_out[13] && !sr_out[15] && !sr_out[14]));

    assert_iack_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_fc == 3'd7) |-> (!bus_we && bus_size == 2'd0));

    assert_push_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_fc == 3'd5));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=>
        (bus_req && $stable(bus_addr) && $stable(bus_fc) && $stable(bus_we)
         && $stable(bus_size) && $stable(bus_wdata)));
endmodule

bind exc_entry_seq exc_entry_chk u_exc_entry_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .sr_out    (sr_out),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_fc    (bus_fc),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_irq = 1'b0;
    logic [7:0]  req_code = '0;
    logic [2:0]  req_level = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc_in = '0, ssp_in = '0, vbr_in = '0;
    logic        busy, done;
    logic [15:0] sr_out;
    logic [31:0] pc_out, ssp_out;
    logic        bus_req, bus_we;
    logic [2:0]  bus_fc;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  cur_ivec = '0;
    logic        cur_ierr = 1'b0;
    int          n_tx = 0;
    logic [31:0] log_addr  [8];
    logic [31:0] log_wdata [8];
    logic [2:0]  log_fc    [8];
    logic [1:0]  log_size  [8];
    logic        log_we    [8];
    int          wait_cnt = 0;
    int          dly = 0;

    always #5 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_irq(req_irq),
        .req_code(req_code), .req_level(req_level), .sr_in(sr_in), .pc_in(pc_in),
        .ssp_in(ssp_in), .vbr_in(vbr_in), .busy(busy), .done(done),
        .sr_out(sr_out), .pc_out(pc_out), .ssp_out(ssp_out),
        .bus_req(bus_req), .bus_we(bus_we), .bus_fc(bus_fc), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    function automatic logic [31:0] handler_of(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [15:0] exp_sr(input logic [15:0] s, input logic irq,
                                           input logic [2:0] lvl);
        logic [15:0] e;
        e = s;
        e[15] = 1'b0;
        e[14] = 1'b0;
        e[13] = 1'b1;
        if (irq) e[10:8] = lvl;
        return e;
    endfunction

    // bus responder: answers at negedge after a random wait
    always @(negedge clk) begin
        if (bus_ack || bus_err) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
        end else if (bus_req) begin
            if (wait_cnt < dly) begin
                wait_cnt++;
            end else begin
                if (n_tx < 8) begin
                    log_addr[n_tx]  = bus_addr;
                    log_wdata[n_tx] = bus_wdata;
                    log_fc[n_tx]    = bus_fc;
                    log_size[n_tx]  = bus_size;
                    log_we[n_tx]    = bus_we;
                end
                n_tx++;
                if (bus_fc == 3'd7) begin
                    if (cur_ierr) bus_err = 1'b1;
                    else begin
                        bus_ack   = 1'b1;
                        bus_rdata = {24'hC3A55A, cur_ivec};
                    end
                end else begin
                    bus_ack   = 1'b1;
                    bus_rdata = bus_we ? 32'h0 : handler_of(bus_addr);
                end
                wait_cnt = 0;
                dly = $urandom_range(0, 3);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_exc(input logic irq, input logic [7:0] code, input logic [2:0] lvl,
                           input logic [15:0] sr, input logic [31:0] pc,
                           input logic [31:0] ssp, input logic [31:0] vbr,
                           input logic [7:0] ivec, input logic ierr);
        logic [7:0]  vec;
        logic [31:0] vaddr;
        int          b;
        int          t;
        vec   = irq ? (ierr ? 8'd24 : ivec) : code;
        vaddr = vbr + {22'd0, vec, 2'b00};
        b     = irq ? 1 : 0;
        @(negedge clk);
        cur_ivec = ivec; cur_ierr = ierr; n_tx = 0;
        req_valid = 1'b1; req_irq = irq; req_code = code; req_level = lvl;
        sr_in = sr; pc_in = pc; ssp_in = ssp; vbr_in = vbr;
        @(negedge clk);
        req_valid = 1'b0;
        sr_in = ~sr; pc_in = ~pc;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R10 done seen", {31'd0, done}, 32'd1);
        chk(n_tx == b + 3, "R6 access count", n_tx, b + 3);
        if (n_tx == b + 3) begin
            if (irq) begin
                chk(log_fc[0] == 3'd7 && !log_we[0] && log_size[0] == 2'd0,
                    "R5 iack kind", {27'd0, log_fc[0], log_size[0]}, {27'd0, 3'd7, 2'd0});
                chk(log_addr[0] == {29'h1FFF_FFFF, lvl}, "R5 iack addr",
                    log_addr[0], {29'h1FFF_FFFF, lvl});
            end
            chk(log_we[b] && log_fc[b] == 3'd5 && log_size[b] == 2'd2,
                "R8 pc push kind", {27'd0, log_fc[b], log_size[b]}, {27'd0, 3'd5, 2'd2});
            chk(log_addr[b] == ssp - 32'd4, "R8 pc push addr", log_addr[b], ssp - 32'd4);
            chk(log_wdata[b] == pc, "R8 pc push data", log_wdata[b], pc);
            chk(log_we[b+1] && log_fc[b+1] == 3'd5 && log_size[b+1] == 2'd1,
                "R8 sr push kind", {27'd0, log_fc[b+1], log_size[b+1]}, {27'd0, 3'd5, 2'd1});
            chk(log_addr[b+1] == ssp - 32'd6, "R8 sr push addr", log_addr[b+1], ssp - 32'd6);
            chk(log_wdata[b+1][15:0] == sr, "R2 saved sr", {16'd0, log_wdata[b+1][15:0]},
                {16'd0, sr});
            chk(!log_we[b+2] && log_fc[b+2] == 3'd5 && log_size[b+2] == 2'd2,
                "R9 fetch kind", {27'd0, log_fc[b+2], log_size[b+2]}, {27'd0, 3'd5, 2'd2});
            chk(log_addr[b+2] == vaddr,
                ierr ? "R7 spurious fetch addr" : "R9 fetch addr", log_addr[b+2], vaddr);
        end
        chk(sr_out == exp_sr(sr, irq, lvl), "R3 R4 sr_out", {16'd0, sr_out},
            {16'd0, exp_sr(sr, irq, lvl)});
        chk(ssp_out == ssp - 32'd6, "R8 ssp_out", ssp_out, ssp - 32'd6);
        chk(pc_out == handler_of(vaddr), "R10 pc_out", pc_out, handler_of(vaddr));
        @(negedge clk);
        chk(!done && !busy, "R10 single done", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R1 reset idle", {29'd0, busy, done, bus_req}, 32'd0);

        // directed corners
        run_exc(1'b0, 8'd5, 3'd2, 16'hFFFF, 32'h0000_1000, 32'h0000_8000,
                32'h0000_0000, 8'd0, 1'b0);                       // R4 mask kept
        run_exc(1'b1, 8'd9, 3'd5, 16'hC700, 32'h0040_0002, 32'h0000_2000,
                32'h0010_0000, 8'd64, 1'b1);                      // R7 spurious
        run_exc(1'b1, 8'd0, 3'd7, 16'h0000, 32'hFFFF_FFFE, 32'h0000_0004,
                32'hFFFF_FF00, 8'd255, 1'b0);                     // wrap, R5
        run_exc(1'b0, 8'd255, 3'd0, 16'h4000, 32'h0000_0100, 32'h0000_0002,
                32'hFFFF_FF80, 8'd0, 1'b0);                       // R6 R9 wrap

        for (int i = 0; i < 40; i++) begin
            run_exc($urandom_range(0, 1) == 1, 8'($urandom), 3'($urandom),
                    16'($urandom), {$urandom} & 32'hFFFF_FFFE, {$urandom} & 32'hFFFF_FFFE,
                    {$urandom}, 8'($urandom), $urandom_range(0, 3) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule